// File: doc/BRIEF.md
# Streaming Horizontal Pixel Downscaler with Luma Filter

The block thins a video line horizontally. It takes one pixel per clock. Each pixel has an 8-bit luma field and an 8-bit chroma field, a valid flag, and a marker for the first pixel of a line. Before decimation, the luma samples pass through a programmable four-tap FIR. The window holds the current sample and the three samples accepted before it. Chroma is not filtered, but it is kept or dropped together with its luma.

Decimation works on groups of m+1 accepted pixels, where m is a 4-bit factor. One mode keeps a single pixel per group. The other mode drops a single pixel per group. One enable bit switches both filtering and decimation. Two pixel-format codes cannot be scaled, and they force plain pass-through. The output stream is qualified by a valid flag, and dropped pixels leave gaps in it.

Top module: `pix_downscaler`

## Requirements
- R1: With `en_i` low, every accepted pixel appears at the output with luma and chroma unchanged.
- R2: The format code on `fmt_i` is one of four values: 0 = YUV 4:2:2, 1 = RGB 5:6:5, 2 = YUV 4:2:0, 3 = YUV 4:4:4. Codes 1 and 2 force the R1 pass-through whatever `en_i` is. Codes 0 and 3 follow `en_i`.
- R3: With `type_i` = 0 and m ≥ 1, only the first pixel of each group of m+1 accepted pixels is output.
- R4: With `type_i` = 1 and m ≥ 1, the first m pixels of each group of m+1 accepted pixels are output and the last one is discarded.
- R5: With m = 0, every pixel is output in both modes.
- R6: The filtered luma is (c1·s0 + c2·s1 + c3·s2 + c4·s3 + 8) >> 4. Here s0 is the current sample and s3 is the oldest of the four. `coef_i[3:0]` holds c1, `[7:4]` holds c2, `[11:8]` holds c3 and `[15:12]` holds c4.
- R7: A filter result above 255 is clamped to 255.
- R8: Chroma leaves the block unfiltered and stays paired with the luma of the same input pixel.
- R9: A line-start pixel restarts the group count at its first position. It also fills the whole filter history with its own luma, so the first outputs of a line use replicated edge samples.
- R10: An output pulse appears exactly two clocks after the edge that accepted its pixel. Dropped pixels, and cycles with `in_valid_i` low, give no pulse and do not advance the group.
- R11: While reset is asserted, `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables filtering and decimation |
| type_i | input | 1 | 0: keep one of m+1; 1: drop one of m+1 |
| factor_i | input | 4 | Decimation factor m |
| coef_i | input | 16 | Four 4-bit filter coefficients, c1 in the low nibble |
| fmt_i | input | 2 | Pixel format code |
| in_valid_i | input | 1 | Input pixel valid |
| in_sol_i | input | 1 | Input pixel is the first of a line |
| in_luma_i | input | 8 | Input luma |
| in_chroma_i | input | 8 | Input chroma |
| out_valid_o | output | 1 | Output pixel valid |
| out_luma_o | output | 8 | Output luma |
| out_chroma_o | output | 8 | Output chroma |

## Verification
The assertions assume that configuration inputs change only between lines, when no pixel is in the pipeline. The unity-gain check also expects any coefficient set that sums to 16 to leave a flat run of samples unchanged. The stimulus changes configuration only after idle cycles that drain the two pipeline stages, and it always starts the next line with a line-start pixel. Coefficient sets that break the sum-of-16 rule appear only in the clamp case, where the unity check has no condition to match.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam logic [1:0] FMT_YUV422 = 2'd0;
  localparam logic [1:0] FMT_RGB565 = 2'd1;
  localparam logic [1:0] FMT_YUV420 = 2'd2;
  localparam logic [1:0] FMT_YUV444 = 2'd3;

  function automatic logic fmt_unscalable(input logic [1:0] f);
    return (f == FMT_RGB565) || (f == FMT_YUV420);
  endfunction
endpackage

// File: rtl/pds_group_ctr.sv
module pds_group_ctr #(
  parameter int FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          sol_i,
  input  logic          type_i,
  input  logic [FW-1:0] m_i,
  output logic          keep_o
);
  logic [FW-1:0] cnt_q;
  logic [FW-1:0] pos;

  assign pos = sol_i ? '0 : cnt_q;

  always_comb begin
    if (m_i == '0)    keep_o = 1'b1;
    else if (type_i)  keep_o = (pos != m_i);
    else              keep_o = (pos == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= (pos >= m_i) ? '0 : pos + 1'b1;
  end

  AST_M0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && m_i == '0) |-> keep_o); // R5
  AST_SOL_FIRST_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && sol_i) |-> keep_o); // R9
endmodule

// File: rtl/pds_luma_hist.sv
module pds_luma_hist #(
  parameter int DW   = 8,
  parameter int TAPS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     sol_i,
  input  logic [DW-1:0]            x_i,
  output logic [TAPS-1:0][DW-1:0]  win_o
);
  logic [TAPS-2:0][DW-1:0] hist_q;

  assign win_o[0] = x_i;

  for (genvar g = 1; g < TAPS; g++) begin : g_win
    assign win_o[g] = sol_i ? x_i : hist_q[g-1];
  end

  for (genvar g = 0; g < TAPS-1; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q[g] <= '0;
      else if (step_i) hist_q[g] <= win_o[g];
    end
  end

  AST_SEED_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && sol_i) |=> (hist_q[0] == $past(x_i)) && (hist_q[TAPS-2] == $past(x_i))); // R9
endmodule

// File: rtl/pds_fir.sv
module pds_fir #(
  parameter int DW   = 8,
  parameter int CW   = 4,
  parameter int TAPS = 4
) (
  input  logic [TAPS-1:0][DW-1:0] win_i,
  input  logic [TAPS*CW-1:0]      coef_i,
  output logic [DW-1:0]           y_o
);
  localparam int PW = DW + CW;
  localparam int SW = PW + $clog2(TAPS) + 1;

  logic [TAPS-1:0][PW-1:0] prod;
  logic [SW-1:0] sum, rnd, q;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign prod[g] = PW'(win_i[g]) * PW'(coef_i[g*CW +: CW]);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + SW'(prod[i]);
    rnd = sum + (SW'(1) << (CW-1));
    q   = rnd >> CW;
    y_o = (q > SW'((1 << DW) - 1)) ? '1 : q[DW-1:0]; // R7 clamp
  end
endmodule

// File: rtl/pix_downscaler.sv
module pix_downscaler
  import pds_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 4,
  parameter int TAPS = 4,
  parameter int FW   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               type_i,
  input  logic [FW-1:0]      factor_i,
  input  logic [TAPS*CW-1:0] coef_i,
  input  logic [1:0]         fmt_i,
  input  logic               in_valid_i,
  input  logic               in_sol_i,
  input  logic [DW-1:0]      in_luma_i,
  input  logic [DW-1:0]      in_chroma_i,
  output logic               out_valid_o,
  output logic [DW-1:0]      out_luma_o,
  output logic [DW-1:0]      out_chroma_o
);
  logic                    act, keep;
  logic [TAPS-1:0][DW-1:0] win;
  logic                    s1_vld_q, s1_act_q;
  logic [TAPS-1:0][DW-1:0] s1_win_q;
  logic [DW-1:0]           s1_chroma_q;
  logic [DW-1:0]           fir_y;

  assign act = en_i && !fmt_unscalable(fmt_i);

  pds_group_ctr #(.FW(FW)) u_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (in_valid_i),
    .sol_i  (in_sol_i),
    .type_i (type_i),
    .m_i    (factor_i),
    .keep_o (keep)
  );

  pds_luma_hist #(.DW(DW), .TAPS(TAPS)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (in_valid_i),
    .sol_i  (in_sol_i),
    .x_i    (in_luma_i),
    .win_o  (win)
  );

  // stage 1: window capture and keep decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q    <= 1'b0;
      s1_act_q    <= 1'b0;
      s1_win_q    <= '0;
      s1_chroma_q <= '0;
    end else begin
      s1_vld_q    <= in_valid_i && (keep || !act);
      s1_act_q    <= act;
      s1_win_q    <= win;
      s1_chroma_q <= in_chroma_i;
    end
  end

  pds_fir #(.DW(DW), .CW(CW), .TAPS(TAPS)) u_fir (
    .win_i  (s1_win_q),
    .coef_i (coef_i),
    .y_o    (fir_y)
  );

  // stage 2: filtered or raw luma
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_luma_o   <= '0;
      out_chroma_o <= '0;
    end else begin
      out_valid_o  <= s1_vld_q;
      out_luma_o   <= s1_act_q ? fir_y : s1_win_q[0];
      out_chroma_o <= s1_chroma_q;
    end
  end

  // assertion support: coefficient sum and flat window
  logic [CW+$clog2(TAPS):0] coef_sum;
  logic                     win_flat;
  always_comb begin
    coef_sum = '0;
    win_flat = 1'b1;
    for (int i = 0; i < TAPS; i++) begin
      coef_sum = coef_sum + ($bits(coef_sum))'(coef_i[i*CW +: CW]);
      if (s1_win_q[i] != s1_win_q[0]) win_flat = 1'b0;
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 2)); // R10
  AST_FMT_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_unscalable(fmt_i)) |=> (s1_vld_q && !s1_act_q)); // R2
  AST_EN_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld_q && !s1_act_q) |=> (out_valid_o && out_luma_o == $past(s1_win_q[0]))); // R1
  AST_UNITY_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_act_q && win_flat && coef_sum == ($bits(coef_sum))'(1 << CW))
      |=> out_luma_o == $past(s1_win_q[0])); // R6
  AST_CHROMA_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_q |=> out_chroma_o == $past(s1_chroma_q)); // R8
endmodule

// File: tb/pix_downscaler_bench.sv
module pix_downscaler_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en, typ;
  logic [3:0]  factor;
  logic [15:0] coef;
  logic [1:0]  fmt;
  logic        in_valid, in_sol;
  logic [7:0]  in_luma, in_chroma;
  logic        out_valid;
  logic [7:0]  out_luma, out_chroma;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_downscaler u_pix_downscaler (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .type_i(typ), .factor_i(factor),
    .coef_i(coef), .fmt_i(fmt), .in_valid_i(in_valid), .in_sol_i(in_sol),
    .in_luma_i(in_luma), .in_chroma_i(in_chroma),
    .out_valid_o(out_valid), .out_luma_o(out_luma), .out_chroma_o(out_chroma)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int h0, h1, h2, cnt, since_sol;
  bit    e1_v, e2_v;
  int    e1_y, e2_y, e1_c, e2_c;
  string e1_tv, e2_tv, e1_ty, e2_ty;

  always @(posedge clk) begin
    bit act, keep, v;
    int pos, s, f, y, c;
    string tv, ty;
    cyc++;
    if (!rst_ni) begin
      e1_v = 0; e2_v = 0; cnt = 0;
    end else begin
      v = 0; y = 0; c = 0; tv = "R10"; ty = "R6";
      if (in_valid) begin
        act = en && !(fmt == 2'd1 || fmt == 2'd2);
        y = in_luma; c = in_chroma;
        if (in_sol) begin h0 = y; h1 = y; h2 = y; pos = 0; since_sol = 0; end
        else begin pos = cnt; since_sol++; end
        keep = (factor == 0) || (typ ? (pos != factor) : (pos == 0));
        cnt = (pos >= factor) ? 0 : pos + 1;
        s = coef[3:0]*y + coef[7:4]*h0 + coef[11:8]*h1 + coef[15:12]*h2;
        f = (s + 8) >> 4;
        h2 = h1; h1 = h0; h0 = y;
        if (!act) begin
          v = 1; tv = en ? "R2" : "R1"; ty = tv;
        end else begin
          v = keep;
          tv = (factor == 0) ? "R5" : (typ ? "R4" : "R3");
          ty = (f > 255) ? "R7" : (since_sol < 3 ? "R9" : "R6");
          if (f > 255) f = 255;
          y = f;
        end
      end
      e2_v = e1_v; e2_y = e1_y; e2_c = e1_c; e2_tv = e1_tv; e2_ty = e1_ty;
      e1_v = v; e1_y = y; e1_c = c; e1_tv = tv; e1_ty = ty;
    end
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      checks++;
      if (out_valid !== 1'b0) begin
        fails++; $display("FAIL R11 out_valid in reset: got %b exp 0", out_valid);
      end
    end else if (!done) begin
      checks++;
      if (out_valid !== e2_v) begin
        fails++; $display("FAIL %s valid: got %b exp %b (cycle %0d)", e2_tv, out_valid, e2_v, cyc);
      end else if (e2_v) begin
        checks++;
        if (out_luma !== e2_y[7:0]) begin
          fails++; $display("FAIL %s luma: got %0d exp %0d (cycle %0d)", e2_ty, out_luma, e2_y, cyc);
        end
        checks++;
        if (out_chroma !== e2_c[7:0]) begin
          fails++; $display("FAIL R8 chroma: got %0d exp %0d (cycle %0d)", out_chroma, e2_c, cyc);
        end
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0; in_sol = 0;
    end
  endtask

  // flat < 0: varying luma pattern; gap: idle cycle after every third pixel (R10)
  task automatic line(int n, int seed, int flat, bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_sol = (i == 0);
      in_luma   = (flat < 0) ? 8'((seed*37 + i*53 + i*i*7) & 255) : 8'(flat);
      in_chroma = 8'((seed*11 + i*29) & 255);
      if (gap && (i % 3 == 2)) idle(1);
    end
    idle(4);
  endtask

  task automatic cfg(bit e, bit t, int m, logic [15:0] c, logic [1:0] f);
    en = e; typ = t; factor = 4'(m); coef = c; fmt = f;
  endtask

  initial begin
    cfg(0, 0, 0, 16'h4444, 2'd0);
    in_valid = 0; in_sol = 0; in_luma = 0; in_chroma = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    idle(2);
    // R1 pass-through
    line(10, 1, -1, 0);
    // R3 type 0, m=2, box filter
    cfg(1, 0, 2, 16'h4444, 2'd0); line(20, 2, -1, 0);
    // R4 type 1, m=3, asymmetric coefficients (R6 ordering)
    cfg(1, 1, 3, 16'h8521, 2'd3); line(21, 3, -1, 0);
    cfg(1, 1, 1, 16'h1258, 2'd0); line(13, 4, -1, 1);
    // R5 m=0 for both types
    cfg(1, 0, 0, 16'h2266, 2'd0); line(9, 5, -1, 0);
    cfg(1, 1, 0, 16'h2266, 2'd3); line(9, 6, -1, 0);
    // R2 unscalable formats ignore enable
    cfg(1, 0, 3, 16'h4444, 2'd1); line(10, 7, -1, 0);
    cfg(1, 1, 2, 16'h4444, 2'd2); line(10, 8, -1, 0);
    // R7 clamp with out-of-rule coefficients
    cfg(1, 0, 1, 16'hFFFF, 2'd0); line(8, 9, 255, 0);
    cfg(1, 1, 2, 16'hF0F0, 2'd3); line(12, 10, -1, 0);
    // R9 back-to-back lines restarting mid-group, R10 gaps
    cfg(1, 0, 4, 16'h1F00, 2'd0);
    line(7, 11, -1, 1); line(3, 12, -1, 0); line(15, 13, -1, 1);
    cfg(1, 1, 15, 16'h0F01, 2'd0); line(40, 14, -1, 1);
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule